// File: doc/BRIEF.md
# Digital Third-Order Cascaded Delta-Sigma Modulator

This block turns an unsigned fractional control word into a stream of small signed integers whose long-run mean equals that word scaled by 2^-N. A typical use is steering a multi-modulus divider in a fractional-N frequency synthesizer. The divider and the loop around it are outside this block.

The block chains three first-order accumulator stages. Each N-bit accumulator adds its input on every enabled clock. The carry out of the addition is that stage's one-bit quantizer decision. The wrapped sum is the stage's residue, and it feeds the next stage in the same cycle. A digital cancellation network merges the three carry streams into one registered word: c1 + (1 - z^-1)·c2 + (1 - z^-1)^2·c3. The first- and second-stage errors cancel, so only the last stage's error remains, shaped by a third-order difference.

The enable input freezes the whole block. While it is low, the accumulators, the carry history and the output all hold their values. Every delay in the cancellation network counts enabled cycles only.

Top module: `mash111_mod`

## Requirements
- R1: While `rst` is high at a rising clock edge, every accumulator, every stored carry and `out_word` become zero.
- R2: On each enabled edge, stage 1 adds `frac_word` to its N-bit accumulator modulo 2^N. Its carry is 1 exactly when the true sum reaches 2^N.
- R3: Stage 2 adds stage 1's new wrapped sum from the same cycle, and stage 3 adds stage 2's new wrapped sum. Each stage keeps its own modulo-2^N accumulator and carry.
- R4: After each enabled edge, `out_word` equals c1 + c2 − c2' + c3 − 2·c3' + c3''. Here c1, c2 and c3 are the carries formed at that edge, a single prime is the carry of the previous enabled edge, and a double prime is the carry from two enabled edges back (zero after reset).
- R5: `out_word` is a 4-bit two's-complement value and always lies in −3..+4.
- R6: While `en` is low, `out_word` and all internal state hold their values. The next enabled edge continues the sequence as if the idle cycles had not occurred.
- R7: With `frac_word` = 0 held from reset, `out_word` stays 0 on every cycle.
- R8: For a constant input x applied from reset, the sum of `out_word` over T enabled cycles is within 4 of T·x/2^N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advances the modulator by one step when high |
| frac_word | input | ACC_W | Unsigned fractional control word |
| out_word | output | 4 | Signed output sample, two's complement |

## Verification
The bench drives a range of constant inputs: zero, the smallest step, the half-scale word, an irregular word, and the all-ones word. Zero confirms that the carry history never leaks. The half-scale word gives a short, easily recognised period. The all-ones word stresses the largest second and third carries and so reaches the range limits. Every step is compared against an integer reference, and the window sums confirm the mean. A run with a word change part-way through, and a run with an irregular enable pattern, tell apart a design that counts delays in clock cycles from one that counts them in enabled steps.

// File: rtl/mash111_pkg.sv
package mash111_pkg;
  localparam int NUM_STAGES = 3;
  localparam int OUT_W      = 4;

  typedef logic signed [OUT_W-1:0] mash_out_t;

  // First difference of the stage-2 carry stream.
  function automatic mash_out_t diff1(input logic cur, input logic prev);
    mash_out_t r;
    r = $signed({3'b000, cur}) - $signed({3'b000, prev});
    return r;
  endfunction

  // Second difference of the stage-3 carry stream.
  function automatic mash_out_t diff2(input logic cur, input logic prev,
                                      input logic prev2);
    mash_out_t r;
    r = $signed({3'b000, cur}) - $signed({2'b00, prev, 1'b0})
        + $signed({3'b000, prev2});
    return r;
  endfunction

  // Cancellation network: first carry plus shaped higher carries.
  function automatic mash_out_t merge(input logic c1, input mash_out_t d1,
                                      input mash_out_t d2);
    mash_out_t r;
    r = $signed({3'b000, c1}) + d1 + d2;
    return r;
  endfunction
endpackage

// File: rtl/mash111_acc_stage.sv
module mash111_acc_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] in_word,
  output logic [W-1:0] residue,
  output logic         carry,
  output logic [W-1:0] acc_q
);
  logic [W:0] sum_full;

  assign sum_full = {1'b0, acc_q} + {1'b0, in_word};
  assign residue  = sum_full[W-1:0];
  assign carry    = sum_full[W];

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= residue;
  end

  // A carry means the accumulator wrapped, so the new value is below the addend.
  assert_carry_wraps_R2: assert property (@(posedge clk) disable iff (rst)
    (en && carry) |=> (acc_q < $past(in_word)));
  assert_no_carry_grows_R2: assert property (@(posedge clk) disable iff (rst)
    (en && !carry) |=> (acc_q >= $past(in_word)));
  assert_stage_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc_q));
endmodule

// File: rtl/mash111_cancel.sv
module mash111_cancel
  import mash111_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      c1,
  input  logic      c2,
  input  logic      c3,
  output mash_out_t out_word,
  output logic      hist_idle
);
  logic      c2_d;
  logic      c3_d;
  logic      c3_dd;
  mash_out_t term2;
  mash_out_t term3;
  mash_out_t next_out;

  assign term2     = diff1(c2, c2_d);
  assign term3     = diff2(c3, c3_d, c3_dd);
  assign next_out  = merge(c1, term2, term3);
  assign hist_idle = !(c2_d || c3_d || c3_dd);

  always_ff @(posedge clk) begin
    if (rst) begin
      c2_d     <= 1'b0;
      c3_d     <= 1'b0;
      c3_dd    <= 1'b0;
      out_word <= '0;
    end else if (en) begin
      c2_d     <= c2;
      c3_d     <= c3;
      c3_dd    <= c3_d;
      out_word <= next_out;
    end
  end

  assert_term2_range_R4: assert property (@(posedge clk) disable iff (rst)
    (term2 >= -4'sd1) && (term2 <= 4'sd1));
  assert_term3_range_R4: assert property (@(posedge clk) disable iff (rst)
    (term3 >= -4'sd2) && (term3 <= 4'sd2));
  assert_out_range_R5: assert property (@(posedge clk) disable iff (rst)
    (out_word >= -4'sd3) && (out_word <= 4'sd4));
  assert_out_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(out_word));
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (out_word == 4'sd0) && hist_idle);
endmodule

// File: rtl/mash111_mod.sv
module mash111_mod
  import mash111_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [ACC_W-1:0]        frac_word,
  output logic signed [OUT_W-1:0] out_word
);
  localparam int NS = NUM_STAGES;

  logic [ACC_W-1:0] stage_in  [NS];
  logic [ACC_W-1:0] stage_res [NS];
  logic [ACC_W-1:0] stage_acc [NS];
  logic [NS-1:0]    stage_carry;
  logic             hist_idle;
  logic             all_acc_zero;

  genvar k;
  generate
    for (k = 0; k < NS; k++) begin : g_stage
      if (k == 0) begin : g_first
        assign stage_in[k] = frac_word;
      end else begin : g_chain
        assign stage_in[k] = stage_res[k-1];
      end
      mash111_acc_stage #(.W(ACC_W)) stage_i (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .in_word (stage_in[k]),
        .residue (stage_res[k]),
        .carry   (stage_carry[k]),
        .acc_q   (stage_acc[k])
      );
    end
  endgenerate

  mash111_cancel cancel_i (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .c1        (stage_carry[0]),
    .c2        (stage_carry[1]),
    .c3        (stage_carry[2]),
    .out_word  (out_word),
    .hist_idle (hist_idle)
  );

  assign all_acc_zero = (stage_acc[0] == '0) && (stage_acc[1] == '0) &&
                        (stage_acc[2] == '0);

  // A zero word on a fully quiet modulator keeps it quiet.
  assert_zero_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (en && frac_word == '0 && all_acc_zero && hist_idle)
      |=> (out_word == 4'sd0) && all_acc_zero);
  assert_reset_acc_R1: assert property (@(posedge clk)
    rst |=> all_acc_zero);
endmodule

// File: tb/mash111_mod_tb_top.sv
`timescale 1ns/1ps
module mash111_mod_tb_top;
  localparam int W = 16;
  localparam longint MOD = 64'd1 << W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              en  = 1'b0;
  logic [W-1:0]      frac_word = '0;
  logic signed [3:0] out_word;

  int n_tests = 0;
  int n_fail  = 0;

  // reference state
  longint a1, a2, a3;
  int c2d, c3d, c3dd, exp_y;

  always #2.5 clk = ~clk;

  mash111_mod #(.ACC_W(W)) dut_i (
    .clk(clk), .rst(rst), .en(en), .frac_word(frac_word), .out_word(out_word)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    a1 = 0; a2 = 0; a3 = 0; c2d = 0; c3d = 0; c3dd = 0; exp_y = 0;
  endtask

  // Restates R2-R4 in plain integer arithmetic.
  task automatic model_step(input longint x);
    longint s1, s2, s3;
    int c1, c2, c3;
    s1 = a1 + x;  c1 = (s1 >= MOD) ? 1 : 0; a1 = s1 % MOD;
    s2 = a2 + a1; c2 = (s2 >= MOD) ? 1 : 0; a2 = s2 % MOD;
    s3 = a3 + a2; c3 = (s3 >= MOD) ? 1 : 0; a3 = s3 % MOD;
    exp_y = c1 + (c2 - c2d) + (c3 - 2 * c3d + c3dd);
    c2d = c2; c3dd = c3d; c3d = c3;
  endtask

  // One clock: reference advances with the DUT, sampled at the falling edge.
  task automatic step(output int y, output bit bad);
    bit was_en;
    was_en = en;
    @(posedge clk);
    if (was_en) model_step(longint'(frac_word));
    @(negedge clk);
    y = int'(out_word);
    bad = (y != exp_y) || (y < -3) || (y > 4);
  endtask

  task automatic do_reset();
    rst = 1'b1; en = 1'b0;
    repeat (3) @(negedge clk);
    model_reset();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    frac_word = 16'hABCD; en = 1'b1; rst = 1'b1;
    repeat (3) @(negedge clk);
    check(out_word == 4'sd0, "R1 reset output", int'(out_word), 0);
    rst = 1'b0; en = 1'b0;
    model_reset();
  endtask

  // Constant word from reset: per-step match (R2 R3 R4 R5) and mean (R8).
  task automatic t_const(input logic [W-1:0] x, input int steps);
    int y, sum, mism, first_bad_y, first_bad_e;
    bit bad;
    longint ideal;
    do_reset();
    frac_word = x; en = 1'b1;
    sum = 0; mism = 0; first_bad_y = 0; first_bad_e = 0;
    for (int i = 0; i < steps; i++) begin
      step(y, bad);
      if (bad && mism == 0) begin first_bad_y = y; first_bad_e = exp_y; end
      if (bad) mism++;
      sum += y;
    end
    check(mism == 0, $sformatf("R4 R5 sequence x=%0d", x), first_bad_y, first_bad_e);
    ideal = (longint'(steps) * longint'(x)) / MOD;
    check((longint'(sum) - ideal <= 4) && (ideal - longint'(sum) <= 4),
          $sformatf("R8 mean x=%0d", x), sum, int'(ideal));
  endtask

  task automatic t_zero();
    int y, nz;
    bit bad;
    do_reset();
    frac_word = '0; en = 1'b1; nz = 0;
    for (int i = 0; i < 300; i++) begin
      step(y, bad);
      if (y != 0) nz++;
    end
    check(nz == 0, "R7 zero input gives zero", nz, 0);
  endtask

  // Word change part-way (R3 chaining, R4 history across the change).
  task automatic t_change();
    int y, mism;
    bit bad;
    do_reset();
    en = 1'b1; frac_word = 16'h1234; mism = 0;
    for (int i = 0; i < 500; i++) begin
      if (i == 200) frac_word = 16'hF00F;
      if (i == 350) frac_word = 16'h0001;
      step(y, bad);
      if (bad) mism++;
    end
    check(mism == 0, "R3 R4 word change", mism, 0);
  endtask

  // Irregular enable: hold while idle (R6), sequence resumes as in R4.
  task automatic t_enable_gaps();
    int y, prev, mism, held_bad;
    bit bad;
    do_reset();
    frac_word = 16'h6A5F; mism = 0; held_bad = 0; prev = 0;
    for (int i = 0; i < 600; i++) begin
      en = ((i % 7) == 2 || (i % 5) == 0) ? 1'b0 : 1'b1;
      if (i == 300) frac_word = 16'hFFFF;
      prev = int'(out_word);
      step(y, bad);
      if (bad) mism++;
      if (!en && y != prev) held_bad++;
    end
    en = 1'b1;
    check(held_bad == 0, "R6 output held while idle", held_bad, 0);
    check(mism == 0, "R6 sequence resumes", mism, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    model_reset();
    t_reset();
    t_zero();
    t_const(16'h0001, 4096);
    t_const(16'h8000, 4096);
    t_const(16'h3039, 8192);
    t_const(16'hFFFF, 4096);
    t_const(16'h5555, 8192);
    t_change();
    t_enable_gaps();
    t_reset();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule